// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. Incoming frames arrive as a stream of 32-bit words. The engine places each frame into memory buffers that software describes with a ring of two-word descriptors. Each descriptor holds an address word, which carries the buffer pointer in its upper thirty bits and two flags in its two lowest bits, and a status word that the engine writes. Software frees a descriptor by clearing its ownership flag. The engine sets that flag again once it has filled the buffer and written the status.

For every frame the engine fetches the current descriptor. If the descriptor is free, the engine streams the frame words into its buffer and writes the status word. It then writes the address word back with the ownership flag set, which hands the buffer to software. A frame longer than one buffer continues into the following descriptors. If the descriptor is still owned by software, the frame is thrown away and a one-cycle buffer-unavailable pulse is raised.

Memory is reached through a single request port and a read-response port, with one read outstanding at a time. Reads return on `m_rsp_valid` in request order. The frame stream follows valid/ready rules: the sender must hold `s_valid`, `s_data` and `s_last` steady until `s_ready` is seen high. Back-pressure from memory (`m_req_ready` low) passes straight through to `s_ready` while frame words are being written.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, no memory request is issued, `s_ready` is low and `buf_unavail` is low.
- R2: Descriptor i occupies the two words at `ring_base + 8*i`: the address word at offset 0 and the status word at offset 4. The buffer base is the address word with bits 1:0 cleared, and frame word k of that buffer is written at buffer base + 4*k.
- R3: After filling a buffer, the engine writes its status word and then writes the address word back with bit 0 (ownership) set. All other bits of the address word are written back unchanged.
- R4: In the status word, bits 13:0 give the number of bytes stored in that buffer (4 per word). Bit 14 is set only in the first buffer of a frame, bit 15 is set only in the last, and bits 31:16 are zero.
- R5: Each buffer holds BUF_WORDS words. A longer frame continues into the next descriptors, and a frame that exactly fills a buffer ends in that buffer with bit 15 set.
- R6: A fetched descriptor whose bit 0 is set is not used. The rest of the frame is accepted and discarded, `buf_unavail` pulses for one cycle on the cycle after the read response, the descriptor is not written, and the ring index does not advance.
- R7: After a descriptor whose address word has bit 1 (wrap) set is handed over, the next descriptor used is index 0.
- R8: While `rx_enable` is low and no frame is in progress, no frame is started: `s_ready` stays low and no memory request is made.
- R9: While `rx_enable` is low and the engine is idle, the ring index returns to zero.
- R10: A memory request that is not accepted holds its address, direction and data until `m_req_ready` is high. `s_ready` is high for a frame word only in the cycle the memory accepts its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Reception enable |
| ring_base | input | AW | Byte address of descriptor 0 |
| s_valid | input | 1 | Frame word valid |
| s_ready | output | 1 | Frame word accepted |
| s_data | input | 32 | Frame word |
| s_last | input | 1 | Last word of the frame |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request accepted |
| m_req_we | output | 1 | 1 = write, 0 = read |
| m_req_addr | output | AW | Byte address of the request |
| m_req_wdata | output | 32 | Write data |
| m_rsp_valid | input | 1 | Read data valid |
| m_rsp_rdata | input | 32 | Read data |
| buf_unavail | output | 1 | One-cycle pulse: frame dropped because the descriptor is owned by software |

## Verification
The assertions check four things on every cycle. A stalled memory request must stay stable. Every write back to the most recently fetched descriptor must carry the ownership flag. Every status write must have a well-formed layout and a byte count within one buffer. An owned descriptor read must be followed by the buffer-unavailable pulse. Other behaviour can only be shown by the directed scenarios, because it depends on ring contents across several frames: where the payload lands, how SOF and EOF are split over a frame that spans buffers, wrap-around to index zero, the index reset while reception is disabled, and the exact-fill boundary.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int LEN_W    = 14;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_FILL,
    ST_STAT,
    ST_HAND,
    ST_DROP
  } rxd_state_t;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] ring_base,
  output logic [AW-1:0] desc_addr
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clear)          idx_q <= '0;
    else if (advance && wrap) idx_q <= '0;
    else if (advance)        idx_q <= idx_q + 1'b1;
  end

  assign desc_addr = ring_base + (AW'(idx_q) << 3);
endmodule

// File: rtl/rxd_buf_fill.sv
module rxd_buf_fill #(
  parameter int AW        = 32,
  parameter int BUF_WORDS = 4,
  parameter int LEN_W     = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [AW-1:0]    buf_base,
  output logic [AW-1:0]    wr_addr,
  output logic             last_slot,
  output logic [LEN_W-1:0] len_bytes
);
  localparam int CNT_W = $clog2(BUF_WORDS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assign wr_addr   = buf_base + (AW'(cnt_q) << 2);
  assign last_slot = (cnt_q == CNT_W'(BUF_WORDS - 1));
  assign len_bytes = LEN_W'(cnt_q) << 2;
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int BUF_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [AW-1:0]     ring_base,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic              m_req_we,
  output logic [AW-1:0]     m_req_addr,
  output logic [WORD_W-1:0] m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic [WORD_W-1:0] m_rsp_rdata,
  output logic              buf_unavail
);
  rxd_state_t        state_q;
  logic [WORD_W-1:0] addr_word_q;
  logic              sof_q, eof_q, bna_q;

  logic [AW-1:0]     desc_addr, fill_addr, buf_base;
  logic              last_slot;
  logic [LEN_W-1:0]  len_bytes;

  logic word_fire, ptr_clear, ptr_adv, fill_start;

  assign buf_base   = AW'({addr_word_q[WORD_W-1:2], 2'b00});
  assign word_fire  = (state_q == ST_FILL) && s_valid && m_req_ready;
  assign ptr_clear  = (state_q == ST_IDLE) && !rx_enable;
  assign ptr_adv    = (state_q == ST_HAND) && m_req_ready;
  assign fill_start = (state_q == ST_WAIT) && m_rsp_valid;

  rxd_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ptr_clear),
    .advance   (ptr_adv),
    .wrap      (addr_word_q[WRAP_BIT]),
    .ring_base (ring_base),
    .desc_addr (desc_addr)
  );

  rxd_buf_fill #(.AW(AW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) fill_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fill_start),
    .step      (word_fire),
    .buf_base  (buf_base),
    .wr_addr   (fill_addr),
    .last_slot (last_slot),
    .len_bytes (len_bytes)
  );

  always_comb begin
    m_req_valid = 1'b0;
    m_req_we    = 1'b0;
    m_req_addr  = desc_addr;
    m_req_wdata = '0;
    case (state_q)
      ST_FETCH: m_req_valid = 1'b1;
      ST_FILL: begin
        m_req_valid = s_valid;
        m_req_we    = 1'b1;
        m_req_addr  = fill_addr;
        m_req_wdata = s_data;
      end
      ST_STAT: begin
        m_req_valid = 1'b1;
        m_req_we    = 1'b1;
        m_req_addr  = desc_addr + AW'(4);
        m_req_wdata = {16'h0000, eof_q, sof_q, len_bytes};
      end
      ST_HAND: begin
        m_req_valid = 1'b1;
        m_req_we    = 1'b1;
        m_req_wdata = addr_word_q | WORD_W'(1);
      end
      default: ;
    endcase
  end

  assign s_ready     = word_fire || (state_q == ST_DROP);
  assign buf_unavail = bna_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_word_q <= '0;
      sof_q       <= 1'b0;
      eof_q       <= 1'b0;
      bna_q       <= 1'b0;
    end else begin
      bna_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (rx_enable && s_valid) begin
          sof_q   <= 1'b1;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (m_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (m_rsp_valid) begin
          addr_word_q <= m_rsp_rdata;
          eof_q       <= 1'b0;
          if (m_rsp_rdata[OWN_BIT]) begin
            bna_q   <= 1'b1;
            state_q <= ST_DROP;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (word_fire) begin
          if (s_last) begin
            eof_q   <= 1'b1;
            state_q <= ST_STAT;
          end else if (last_slot) begin
            state_q <= ST_STAT;
          end
        end
        ST_STAT: if (m_req_ready) state_q <= ST_HAND;
        ST_HAND: if (m_req_ready) begin
          sof_q   <= 1'b0;
          state_q <= eof_q ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (s_valid && s_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
  parameter int AW        = 32,
  parameter int BUF_WORDS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_req_valid,
  input logic          m_req_ready,
  input logic          m_req_we,
  input logic [AW-1:0] m_req_addr,
  input logic [31:0]   m_req_wdata,
  input logic          m_rsp_valid,
  input logic [31:0]   m_rsp_rdata,
  input logic          buf_unavail
);
  logic [AW-1:0] rd_addr_q;
  logic          rd_seen_q;
  logic          wr_fire;

  assign wr_fire = m_req_valid && m_req_ready && m_req_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_seen_q <= 1'b0;
    end else if (m_req_valid && m_req_ready && !m_req_we) begin
      rd_addr_q <= m_req_addr;
      rd_seen_q <= 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr) &&
      $stable(m_req_we) && $stable(m_req_wdata))); // R10

  AST_HANDOVER_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_seen_q && m_req_addr == rd_addr_q) |-> m_req_wdata[0]); // R3

  AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_seen_q && m_req_addr == rd_addr_q + AW'(4)) |->
      (m_req_wdata[31:16] == 16'h0 && m_req_wdata[13:0] != 14'h0 &&
       m_req_wdata[13:0] <= 14'(BUF_WORDS * 4))); // R4

  AST_OWNED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rsp_valid && m_rsp_rdata[0]) |=> buf_unavail); // R6
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.AW(AW), .BUF_WORDS(BUF_WORDS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_req_valid (m_req_valid),
  .m_req_ready (m_req_ready),
  .m_req_we    (m_req_we),
  .m_req_addr  (m_req_addr),
  .m_req_wdata (m_req_wdata),
  .m_rsp_valid (m_rsp_valid),
  .m_rsp_rdata (m_rsp_rdata),
  .buf_unavail (buf_unavail)
);

// File: tb/rxd_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        m_req_valid, m_req_we;
  logic [31:0] m_req_addr, m_req_wdata;
  logic        mem_ready = 1'b1;
  logic        m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_rdata = '0;
  logic        buf_unavail;
  logic        bp_mode = 1'b0;
  logic [1:0]  bp_cnt = '0;
  int          bna_cnt = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [31:0] mem [0:255];

  always #2 clk = ~clk;

  rxd_ring_writer #(.AW(32), .IDX_W(8), .BUF_WORDS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_req_valid(m_req_valid), .m_req_ready(mem_ready), .m_req_we(m_req_we),
    .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata),
    .buf_unavail(buf_unavail)
  );

  always @(posedge clk) begin
    bp_cnt      <= bp_cnt + 2'd1;
    mem_ready   <= bp_mode ? (bp_cnt != 2'd0) : 1'b1;
    m_rsp_valid <= m_req_valid && mem_ready && !m_req_we;
    m_rsp_rdata <= mem[m_req_addr[9:2]];
    if (m_req_valid && mem_ready && m_req_we) mem[m_req_addr[9:2]] <= m_req_wdata;
    if (buf_unavail) bna_cnt <= bna_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic l);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = l;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_frame(input int nw, input logic [7:0] id);
    for (int k = 0; k < nw; k++) push({id, 24'(k)}, k == nw - 1);
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic set_desc(input int i, input logic [31:0] aw);
    @(negedge clk);
    mem[64 + 2*i]     <= aw;
    mem[64 + 2*i + 1] <= 32'h0;
    @(negedge clk);
  endtask

  task automatic chk_buf(input string req, input int base_w, input int first, input int nw, input logic [7:0] id);
    for (int k = 0; k < nw; k++) check(req, mem[base_w + k], {id, 24'(first + k)});
  endtask

  task automatic t_reset;
    #1;
    check("R1 req_valid", {31'b0, m_req_valid}, 32'd0);
    check("R1 s_ready", {31'b0, s_ready}, 32'd0);
    check("R1 buf_unavail", {31'b0, buf_unavail}, 32'd0);
  endtask

  task automatic t_single;
    send_frame(2, 8'h11);
    chk_buf("R2 payload", 128, 0, 2, 8'h11);
    check("R4 status single", mem[65], 32'h0000_C008);
    check("R3 handover", mem[64], 32'h0000_0201);
  endtask

  task automatic t_span_wrap;
    send_frame(6, 8'h22);
    chk_buf("R5 first buffer", 132, 0, 4, 8'h22);
    chk_buf("R5 second buffer", 136, 4, 2, 8'h22);
    check("R4 status sof", mem[67], 32'h0000_4010);
    check("R4 status eof", mem[69], 32'h0000_8008);
    check("R3 handover wrap bit kept", mem[68], 32'h0000_0223);
  endtask

  task automatic t_owned_drop;
    int b0;
    b0 = bna_cnt;
    send_frame(3, 8'h33);
    check("R6 pulse count", 32'(bna_cnt - b0), 32'd1);
    check("R6 descriptor untouched", mem[64], 32'h0000_0201);
    check("R6 status untouched", mem[65], 32'h0000_C008);
    check("R6 buffer untouched", mem[128], 32'h1100_0000);
    set_desc(0, 32'h200);
    send_frame(4, 8'h44);
    chk_buf("R7 wrapped to index 0", 128, 0, 4, 8'h44);
    check("R5 exact fill status", mem[65], 32'h0000_C010);
    check("R7 handover", mem[64], 32'h0000_0201);
  endtask

  task automatic t_disable;
    int bad;
    bad = 0;
    @(negedge clk); rx_enable = 1'b0;
    repeat (3) @(negedge clk);
    s_valid = 1'b1; s_data = 32'hDEAD_0000; s_last = 1'b1;
    for (int c = 0; c < 8; c++) begin
      #1;
      if (s_ready || m_req_valid) bad++;
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    check("R8 nothing started while disabled", 32'(bad), 32'd0);
    set_desc(0, 32'h200); set_desc(1, 32'h210); set_desc(2, 32'h222);
    @(negedge clk); rx_enable = 1'b1;
    send_frame(1, 8'h55);
    check("R9 index reset status", mem[65], 32'h0000_C004);
    check("R9 index reset data", mem[128], 32'h5500_0000);
    check("R9 desc1 unused", mem[67], 32'h0);
  endtask

  task automatic t_backpressure;
    bp_mode = 1'b1;
    send_frame(5, 8'h66);
    repeat (20) @(negedge clk);
    bp_mode = 1'b0;
    chk_buf("R10 data under stalls", 132, 0, 4, 8'h66);
    chk_buf("R10 tail under stalls", 136, 4, 1, 8'h66);
    check("R10 status sof", mem[67], 32'h0000_4010);
    check("R10 status eof", mem[69], 32'h0000_8004);
    check("R10 handover", mem[68], 32'h0000_0223);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[64] = 32'h200; mem[66] = 32'h210; mem[68] = 32'h222;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); rx_enable = 1'b1;
    t_single();
    t_span_wrap();
    t_owned_drop();
    t_disable();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule